// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines and raises one of two processor interrupt lines from them: a critical line and a normal line. Each source can be set to active-high or active-low, and to level or edge sensitivity. Captured requests land in a status register that software reads, clears by writing ones, and can also force by writing ones to a separate set address. An enable register masks the status. A critical-select register chooses which output each enabled source drives.

A vector register turns the winning pending source into a handler address: a programmable base plus the source's rank times 512. Bit 0 of the vector configuration register sets the priority direction. The register port is a plain single-cycle interface. A write takes effect on the clock edge it is presented at, and read data is combinational from the address.

Top module: `irqc_top`

## Requirements
- R1: After reset, status, enable, critical-select, trigger and vector configuration read 0, polarity reads all ones, and both interrupt outputs are low.
- R2: An input change is visible in the status register after the third rising clock edge, and the interrupt outputs follow one edge after the status.
- R3: Source N occupies register bit 31−N. In the polarity register (byte offset 0x10), 0 makes a source active-low and 1 makes it active-high.
- R4: With trigger bit 0 (level, offset 0x14), a write of 1 to the status bit (offset 0x00) leaves it set while the input is active, and clears it once the input is inactive.
- R5: With trigger bit 1 (edge), status is set only on an inactive-to-active transition and stays clear after a write-1-to-clear until the next such transition.
- R6: A write to the status-set address (offset 0x04) ORs its ones into status, and a write to offset 0x00 clears exactly the bits written as 1.
- R7: The masked status (offset 0x18) reads as status AND enable (offset 0x08).
- R8: The critical output is high when a masked-status bit has its critical-select bit (offset 0x0C) set, and the normal output when one has it clear. Both outputs are registered.
- R9: With configuration (offset 0x20) bit 0 = 1, the vector (offset 0x1C) is (config & ~3) + N*512 for the lowest-numbered pending masked source N.
- R10: With configuration bit 0 = 0, the vector is (config & ~3) + (31−N)*512 for the highest-numbered pending masked source N.
- R11: With no masked source pending, the vector reads (config & ~3), and the configuration reads back all 32 written bits.
- R12: Writes to the masked-status and vector addresses change no state, and reads at word offsets beyond 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Asynchronous request lines, bit N is source N |
| reg_addr_i | input | 6 | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_crit_o | output | 1 | Critical interrupt request |
| irq_norm_o | output | 1 | Normal interrupt request |

## Verification
The hardest states to reach are those where a clear write and a live request meet on the same source. These are a level source cleared while its input is still active, and an edge source cleared while its input stays high. In both cases the input must first travel through the synchronizer. The stimulus holds the input steady for several cycles, issues the clear, and reads status back while the input is still held. It then drops and re-raises the input to show that only a new edge re-arms the bit. The vector cases load several pending bits at once through the set address, so both priority directions and the end sources 0 and 31 can be checked without timing any input.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word index of each register in the window (byte offset / 4).
    typedef enum int unsigned {
        REG_STAT = 0,
        REG_SETS = 1,
        REG_ENAB = 2,
        REG_CRIT = 3,
        REG_POLR = 4,
        REG_TRIG = 5,
        REG_MASK = 6,
        REG_VECT = 7,
        REG_VCFG = 8
    } reg_idx_e;

    localparam int unsigned NUM_REGS = 9;

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_SRC-1:0] irq_src_i,   // source order
    input  logic [DATA_W-1:0] pol_i,       // register order
    input  logic [DATA_W-1:0] trig_i,      // register order
    output logic [DATA_W-1:0] evt_o        // register order
);

    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] prev;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_SRC-1:0] act;
    logic [NUM_SRC-1:0] pol_src;
    logic [NUM_SRC-1:0] trig_src;
    logic [NUM_SRC-1:0] evt_src;

    // Map register bit (DATA_W-1-n) to source n.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
        assign pol_src[n]  = pol_i[DATA_W-1-n];
        assign trig_src[n] = trig_i[DATA_W-1-n];
        assign evt_o[DATA_W-1-n] = evt_src[n];
    end

    if (DATA_W > NUM_SRC) begin : g_pad
        assign evt_o[DATA_W-NUM_SRC-1:0] = '0;
    end

    always_comb begin
        cap_d = cap_q;
        // Polarity applied before edge detection: 1 = active-high.
        act = cap_q.s2 ^ ~pol_src;
        for (int n = 0; n < NUM_SRC; n++) begin
            evt_src[n] = trig_src[n] ? (act[n] & ~cap_q.prev[n]) : act[n];
        end
        cap_d.s1   = irq_src_i;
        cap_d.s2   = cap_q.s1;
        cap_d.prev = act;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // An edge-sensitive source never reports two events on consecutive cycles.
    assert_edge_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_src & trig_src & $past(evt_src & trig_src)) == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] vec_i,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] enab_o,
    output logic [DATA_W-1:0] crit_o,
    output logic [DATA_W-1:0] polr_o,
    output logic [DATA_W-1:0] trig_o,
    output logic [DATA_W-1:0] vcfg_o
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] SRC_MASK = ~({DATA_W{1'b1}} >> NUM_SRC);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] enab;
        logic [DATA_W-1:0] crit;
        logic [DATA_W-1:0] polr;
        logic [DATA_W-1:0] trig;
        logic [DATA_W-1:0] vcfg;
    } regs_t;

    regs_t reg_d, reg_q;
    logic [WORD_W-1:0]   word;
    logic [NUM_REGS-1:0] sel;
    logic [DATA_W-1:0]   set_mask;
    logic [DATA_W-1:0]   clr_mask;
    logic                unused_addr_lsb;

    assign word            = addr_i[ADDR_W-1:2];
    assign unused_addr_lsb = ^addr_i[1:0];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        assign sel[k] = (word == WORD_W'(k));
    end

    always_comb begin
        reg_d    = reg_q;
        set_mask = (wr_i && sel[REG_SETS]) ? (wdata_i & SRC_MASK) : '0;
        clr_mask = (wr_i && sel[REG_STAT]) ? wdata_i : '0;
        // Capture and forced set take precedence over a clear in the same cycle.
        reg_d.stat = ((reg_q.stat & ~clr_mask) | set_mask | evt_i) & SRC_MASK;
        if (wr_i) begin
            if (sel[REG_ENAB]) reg_d.enab = wdata_i & SRC_MASK;
            if (sel[REG_CRIT]) reg_d.crit = wdata_i & SRC_MASK;
            if (sel[REG_POLR]) reg_d.polr = wdata_i & SRC_MASK;
            if (sel[REG_TRIG]) reg_d.trig = wdata_i & SRC_MASK;
            if (sel[REG_VCFG]) reg_d.vcfg = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q      <= '0;
            reg_q.polr <= SRC_MASK;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel[REG_STAT]) rdata_o = reg_q.stat;
        if (sel[REG_SETS]) rdata_o = '0;
        if (sel[REG_ENAB]) rdata_o = reg_q.enab;
        if (sel[REG_CRIT]) rdata_o = reg_q.crit;
        if (sel[REG_POLR]) rdata_o = reg_q.polr;
        if (sel[REG_TRIG]) rdata_o = reg_q.trig;
        if (sel[REG_MASK]) rdata_o = reg_q.stat & reg_q.enab;
        if (sel[REG_VECT]) rdata_o = vec_i;
        if (sel[REG_VCFG]) rdata_o = reg_q.vcfg;
    end

    assign stat_o = reg_q.stat;
    assign enab_o = reg_q.enab;
    assign crit_o = reg_q.crit;
    assign polr_o = reg_q.polr;
    assign trig_o = reg_q.trig;
    assign vcfg_o = reg_q.vcfg;

    // A cleared bit with no capture in the clear cycle reads 0 afterwards.
    assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel[REG_STAT]) |=> ((reg_q.stat & $past(wdata_i & ~evt_i)) == '0));

    // Forced bits are present after a set write.
    assert_force_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel[REG_SETS]) |=>
            ((reg_q.stat & $past(wdata_i & SRC_MASK)) == $past(wdata_i & SRC_MASK)));

    // A status bit rises only from a capture event or a forced set.
    assert_rise_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((reg_q.stat & ~$past(reg_q.stat) & ~$past(evt_i | set_mask)) == '0));

    // Writes to read-only addresses leave the writable registers untouched.
    assert_readonly_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (sel[REG_MASK] || sel[REG_VECT])) |=>
            ($stable(reg_q.enab) && $stable(reg_q.crit) && $stable(reg_q.polr)
             && $stable(reg_q.trig) && $stable(reg_q.vcfg)));

endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned VEC_SHIFT = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0] enab_i,
    input  logic [DATA_W-1:0] crit_i,
    input  logic [DATA_W-1:0] vcfg_i,
    output logic [DATA_W-1:0] vec_o,
    output logic              irq_crit_o,
    output logic              irq_norm_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic crit;
        logic norm;
    } line_t;

    line_t line_d, line_q;
    logic [DATA_W-1:0] pend;
    logic [DATA_W-1:0] base;
    logic [IDX_W-1:0]  lo_n;
    logic [IDX_W-1:0]  hi_n;
    logic [IDX_W-1:0]  rank;
    logic              any;

    assign pend = stat_i & enab_i;
    assign base = {vcfg_i[DATA_W-1:2], 2'b00};

    // Scan sources in ascending order: first hit is lowest N, last is highest N.
    always_comb begin
        lo_n = '0;
        hi_n = '0;
        any  = 1'b0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (pend[DATA_W-1-n]) begin
                if (!any) lo_n = IDX_W'(n);
                hi_n = IDX_W'(n);
                any  = 1'b1;
            end
        end
        rank  = vcfg_i[0] ? lo_n : IDX_W'(NUM_SRC - 1) - hi_n;
        vec_o = any ? base + (DATA_W'(rank) << VEC_SHIFT) : base;
    end

    always_comb begin
        line_d      = line_q;
        line_d.crit = |(pend & crit_i);
        line_d.norm = |(pend & ~crit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign irq_crit_o = line_q.crit;
    assign irq_norm_o = line_q.norm;

    // With nothing pending the vector is the aligned base.
    assert_idle_base_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend == '0) |-> (vec_o == (vcfg_i & ~DATA_W'(3))));

    // A raised output implies a matching pending source one cycle earlier.
    assert_crit_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_crit_o |-> $past((stat_i & enab_i & crit_i) != '0));
    assert_norm_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_norm_o |-> $past((stat_i & enab_i & ~crit_i) != '0));

    // Vector stays inside the window of ranks above the base.
    assert_vec_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_o - base) <= (DATA_W'(NUM_SRC - 1) << VEC_SHIFT));

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned VEC_SHIFT = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_crit_o,
    output logic               irq_norm_o
);

    logic [DATA_W-1:0] evt;
    logic [DATA_W-1:0] vec;
    logic [DATA_W-1:0] stat, enab, crit, polr, trig, vcfg;

    irqc_capture #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) i_capture (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .irq_src_i (irq_src_i),
        .pol_i     (polr),
        .trig_i    (trig),
        .evt_o     (evt)
    );

    irqc_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .evt_i   (evt),
        .vec_i   (vec),
        .stat_o  (stat),
        .enab_o  (enab),
        .crit_o  (crit),
        .polr_o  (polr),
        .trig_o  (trig),
        .vcfg_o  (vcfg)
    );

    irqc_resolve #(
        .NUM_SRC   (NUM_SRC),
        .DATA_W    (DATA_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) i_resolve (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stat_i     (stat),
        .enab_i     (enab),
        .crit_i     (crit),
        .vcfg_i     (vcfg),
        .vec_o      (vec),
        .irq_crit_o (irq_crit_o),
        .irq_norm_o (irq_norm_o)
    );

    // Both outputs low whenever no enabled source was pending a cycle ago (R1, R8).
    assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past((stat & enab) == '0) |-> (!irq_crit_o && !irq_norm_o));

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] A_STAT = 6'h00;
    localparam logic [5:0] A_SETS = 6'h04;
    localparam logic [5:0] A_ENAB = 6'h08;
    localparam logic [5:0] A_CRIT = 6'h0C;
    localparam logic [5:0] A_POLR = 6'h10;
    localparam logic [5:0] A_TRIG = 6'h14;
    localparam logic [5:0] A_MASK = 6'h18;
    localparam logic [5:0] A_VECT = 6'h1C;
    localparam logic [5:0] A_VCFG = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        crit_o, norm_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top i_irqc_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_src_i   (irq_src),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_crit_o  (crit_o),
        .irq_norm_o  (norm_o)
    );

    function automatic logic [31:0] bit_of(input int n);
        return 32'h8000_0000 >> n;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wipe();
        irq_src = '0;
        idle(4);
        wr_reg(A_ENAB, '0);
        wr_reg(A_CRIT, '0);
        wr_reg(A_TRIG, '0);
        wr_reg(A_POLR, '1);
        wr_reg(A_VCFG, '0);
        idle(4);
        wr_reg(A_STAT, '1);
        idle(2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(A_STAT, v); check("R1", "status", v, 32'h0);
        rd_reg(A_ENAB, v); check("R1", "enable", v, 32'h0);
        rd_reg(A_CRIT, v); check("R1", "critical select", v, 32'h0);
        rd_reg(A_POLR, v); check("R1", "polarity", v, 32'hFFFF_FFFF);
        rd_reg(A_TRIG, v); check("R1", "trigger", v, 32'h0);
        rd_reg(A_VCFG, v); check("R1", "vector config", v, 32'h0);
        check("R1", "crit out", {31'b0, crit_o}, 32'h0);
        check("R1", "norm out", {31'b0, norm_o}, 32'h0);
    endtask

    task automatic t_latency();
        wr_reg(A_ENAB, bit_of(5));
        @(negedge clk);
        addr = A_STAT;
        irq_src[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2", "status before third edge", rdata & bit_of(5), 32'h0);
        @(negedge clk);
        check("R2", "status after third edge", rdata & bit_of(5), bit_of(5));
        check("R2", "norm not yet", {31'b0, norm_o}, 32'h0);
        @(negedge clk);
        check("R2", "norm one edge later", {31'b0, norm_o}, 32'h1);
        check("R8", "crit stays low", {31'b0, crit_o}, 32'h0);
        wipe();
    endtask

    task automatic t_polarity_level();
        logic [31:0] v;
        wr_reg(A_POLR, ~bit_of(7));
        idle(4);
        rd_reg(A_STAT, v); check("R3", "active-low source idle at 0", v, bit_of(7));
        wr_reg(A_STAT, bit_of(7));
        rd_reg(A_STAT, v); check("R4", "level clear while active", v, bit_of(7));
        irq_src[7] = 1'b1;
        idle(4);
        wr_reg(A_STAT, bit_of(7));
        rd_reg(A_STAT, v); check("R4", "level clear when inactive", v, 32'h0);
        irq_src[7] = 1'b0;
        idle(4);
        rd_reg(A_STAT, v); check("R3", "reactivated low input", v, bit_of(7));
        wipe();
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr_reg(A_TRIG, bit_of(10));
        irq_src[10] = 1'b1;
        idle(4);
        rd_reg(A_STAT, v); check("R5", "rising edge captured", v, bit_of(10));
        wr_reg(A_STAT, bit_of(10));
        idle(3);
        rd_reg(A_STAT, v); check("R5", "stays clear with input high", v, 32'h0);
        irq_src[10] = 1'b0;
        idle(4);
        rd_reg(A_STAT, v); check("R5", "falling edge ignored", v, 32'h0);
        irq_src[10] = 1'b1;
        idle(4);
        rd_reg(A_STAT, v); check("R5", "new edge re-arms", v, bit_of(10));
        wipe();
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr_reg(A_SETS, bit_of(20) | bit_of(21));
        rd_reg(A_STAT, v); check("R6", "forced bits", v, 32'h0000_0C00);
        wr_reg(A_STAT, bit_of(20));
        rd_reg(A_STAT, v); check("R6", "selective clear", v, 32'h0000_0400);
        wr_reg(A_SETS, bit_of(0));
        rd_reg(A_STAT, v); check("R6", "set ORs in", v, 32'h8000_0400);
        wipe();
    endtask

    task automatic t_mask_outputs();
        logic [31:0] v;
        wr_reg(A_SETS, 32'hF0F0_0000);
        wr_reg(A_ENAB, 32'h3C3C_0000);
        rd_reg(A_MASK, v); check("R7", "masked status", v, 32'h3030_0000);
        check("R8", "norm with no critical", {31'b0, norm_o}, 32'h1);
        check("R8", "crit with no critical", {31'b0, crit_o}, 32'h0);
        wr_reg(A_CRIT, 32'h3030_0000);
        @(negedge clk);
        check("R8", "norm all critical", {31'b0, norm_o}, 32'h0);
        check("R8", "crit all critical", {31'b0, crit_o}, 32'h1);
        wr_reg(A_CRIT, 32'h1000_0000);
        @(negedge clk);
        check("R8", "norm split", {31'b0, norm_o}, 32'h1);
        check("R8", "crit split", {31'b0, crit_o}, 32'h1);
        // R12: read-only addresses and holes
        wr_reg(A_MASK, '1);
        wr_reg(A_VECT, '1);
        rd_reg(A_ENAB, v); check("R12", "enable after ro write", v, 32'h3C3C_0000);
        rd_reg(A_STAT, v); check("R12", "status after ro write", v, 32'hF0F0_0000);
        rd_reg(A_VCFG, v); check("R12", "config after ro write", v, 32'h0);
        rd_reg(6'h24, v);  check("R12", "hole 0x24", v, 32'h0);
        rd_reg(6'h3C, v);  check("R12", "hole 0x3C", v, 32'h0);
        wr_reg(A_ENAB, '0);
        @(negedge clk);
        check("R8", "outputs off when disabled", {30'b0, crit_o, norm_o}, 32'h0);
        wipe();
    endtask

    task automatic t_vector();
        logic [31:0] v;
        wr_reg(A_ENAB, '1);
        wr_reg(A_VCFG, 32'h1000_0003);
        rd_reg(A_VCFG, v); check("R11", "config readback", v, 32'h1000_0003);
        rd_reg(A_VECT, v); check("R11", "idle vector", v, 32'h1000_0000);
        wr_reg(A_SETS, bit_of(3) | bit_of(12));
        rd_reg(A_VECT, v); check("R9", "low-first 3,12", v, 32'h1000_0600);
        wr_reg(A_VCFG, 32'h1000_0002);
        rd_reg(A_VECT, v); check("R10", "high-first 3,12", v, 32'h1000_2600);
        wr_reg(A_ENAB, ~bit_of(12));
        rd_reg(A_VECT, v); check("R10", "disabled 12 skipped", v, 32'h1000_3800);
        wr_reg(A_VCFG, 32'h1000_0003);
        wr_reg(A_ENAB, ~bit_of(3));
        rd_reg(A_VECT, v); check("R9", "disabled 3 skipped", v, 32'h1000_1800);
        wr_reg(A_ENAB, '1);
        wr_reg(A_STAT, '1);
        wr_reg(A_SETS, bit_of(31));
        rd_reg(A_VECT, v); check("R9", "source 31 low-first", v, 32'h1000_3E00);
        wr_reg(A_VCFG, 32'h1000_0000);
        rd_reg(A_VECT, v); check("R10", "source 31 high-first", v, 32'h1000_0000);
        wr_reg(A_STAT, '1);
        wr_reg(A_SETS, bit_of(0));
        rd_reg(A_VECT, v); check("R10", "source 0 high-first", v, 32'h1000_3E00);
        wr_reg(A_STAT, '1);
        rd_reg(A_VECT, v); check("R11", "idle after clear", v, 32'h1000_0000);
        wipe();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_latency();
        t_polarity_level();
        t_edge();
        t_set_clear();
        t_mask_outputs();
        t_vector();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule